// File: doc/BRIEF.md
# Dual-Issue Pipe Assignment Unit

This unit sits between instruction decode and two execution pipes. In each cycle it receives up to two decoded instructions in program order, each tagged with a 4-bit class code. It decides which of them issue and reports, for each slot, a one-hot or two-hot mask of the pipes it occupies. Pipe 0 and pipe 1 accept different class sets: some classes run on either pipe, some on one pipe only, and a few occupy both pipes. The grants and masks are combinational functions of the current inputs and the held state, so a grant in cycle t issues the instruction in cycle t.

The unit also keeps the occupancy of the shared non-pipelined resources. The iterative divider/square-root unit stays busy for a class-dependent number of cycles. The vector unit stays busy one extra cycle after a wide vector operation. A wide vector store pair keeps both pipes occupied in the cycle after it issues. Issue is strictly in order: if the older slot cannot issue, the younger slot waits as well. The stall output tells the front end that at least one offered instruction did not issue.

Top module: `ppa_dual_issue`

## Requirements
- R1: After reset all shared resources are free. With no valid slot, grant_o is 00, both pipe masks are 00 and stall_o is 0. A divider-class instruction offered in the first cycle after reset issues.
- R2: Flexible classes (0 ALU/move/logic/shift) may go to either pipe. Two flexible instructions issue together, with slot 0 on pipe 0 (mask 01) and slot 1 on pipe 1 (mask 10).
- R3: Classes 2 (load) and 3 (store) issue only on pipe 0. Classes 1 (multiply/count-leading-zeros), 4 (branch/trap/call), 5 (scalar FP), 8 to 12 (divider classes), 13 (vector) and 14 (wide vector) issue only on pipe 1. When two instructions need the same single pipe, only slot 0 issues.
- R4: A flexible slot 0 paired with a pipe-0-only slot 1 moves to pipe 1 so that both issue. A pipe-1-only slot 0 places an eligible slot 1 on pipe 0. The two granted masks never overlap.
- R5: Slot 1 is never granted unless slot 0 is granted in the same cycle.
- R6: Classes 6 (pair store/wide load pair), 7 (wide vector store pair) and 15 (unknown/multi) occupy both pipes (mask 11) and issue alone. In slot 1 such an instruction is not granted while slot 0 issues, and no slot 1 issues beside one in slot 0.
- R7: After class 7 issues, no instruction issues in the following cycle.
- R8: After a divider-class instruction issues, the divider stays busy for a further 21 cycles (class 8, integer divide), 8 (class 9), 18 (class 10), 13 (class 11) or 31 (class 12). No divider-class instruction issues while it is busy.
- R9: Class 14 keeps the vector unit busy for one cycle after issue, so a class 13 or 14 instruction in the next cycle waits. Class 13 leaves the unit free in the next cycle.
- R10: stall_o is 1 exactly when some valid slot is not granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s0_vld_i | input | 1 | Slot 0 (older) instruction valid |
| s0_cls_i | input | 4 | Slot 0 class code |
| s1_vld_i | input | 1 | Slot 1 (younger) instruction valid |
| s1_cls_i | input | 4 | Slot 1 class code |
| grant_o | output | 2 | Issue grant, bit 0 for slot 0, bit 1 for slot 1 |
| s0_pipe_o | output | 2 | Pipes used by slot 0 (bit 0 pipe 0, bit 1 pipe 1), 00 if not granted |
| s1_pipe_o | output | 2 | Pipes used by slot 1, 00 if not granted |
| stall_o | output | 1 | Some valid slot was not granted this cycle |

## Verification
The bench builds the unit with its default hold lengths (21, 8, 18, 13 and 31 further divider cycles), so the longest divider window and the counter width it needs are exercised directly. Directed sequences count the blocked cycles between back-to-back divider instructions, and the random run interleaves divider, vector and wide-store holds with every pairing of pipe eligibility.

// File: rtl/ppa_pkg.sv
// Package: class codes and per-class issue attributes shared by the
// pipe assignment unit. Assumes a 4-bit class code from decode.
package ppa_pkg;

    localparam int CLS_W = 4;

    typedef enum logic [CLS_W-1:0] {
        CL_ALU    = 4'd0,
        CL_MUL    = 4'd1,
        CL_LOAD   = 4'd2,
        CL_STORE  = 4'd3,
        CL_BRANCH = 4'd4,
        CL_FPOP   = 4'd5,
        CL_PAIR   = 4'd6,
        CL_VSTQ   = 4'd7,
        CL_IDIV   = 4'd8,
        CL_FDIVS  = 4'd9,
        CL_FDIVD  = 4'd10,
        CL_FSQRTS = 4'd11,
        CL_FSQRTD = 4'd12,
        CL_VEC    = 4'd13,
        CL_VECQ   = 4'd14,
        CL_OPAQUE = 4'd15
    } iclass_e;

    // Resource indices for the busy trackers.
    localparam int RES_DIV   = 0;
    localparam int RES_VEC   = 1;
    localparam int RES_PIPES = 2;
    localparam int NUM_RES   = 3;

    typedef struct packed {
        logic p0_ok;      // may run on pipe 0
        logic p1_ok;      // may run on pipe 1
        logic dual;       // occupies both pipes
        logic use_div;    // claims the divider
        logic use_vec;    // claims the vector unit
        logic hold_pipes; // keeps both pipes for one more cycle
    } cls_info_t;

endpackage

// File: rtl/ppa_class_decode.sv
// Module: ppa_class_decode
// Maps one class code to its pipe eligibility, resource claims and the
// number of further cycles the claimed resource stays busy.
// Assumes at most one resource is claimed per class.
module ppa_class_decode
    import ppa_pkg::*;
#(
    parameter int HOLD_W      = 5,
    parameter int IDIV_HOLD   = 21,
    parameter int FDIVS_HOLD  = 8,
    parameter int FDIVD_HOLD  = 18,
    parameter int FSQRTS_HOLD = 13,
    parameter int FSQRTD_HOLD = 31
) (
    input  logic [CLS_W-1:0]  cls_i,
    output cls_info_t         info_o,
    output logic [HOLD_W-1:0] hold_o
);

    // Per-class attribute lookup.
    always_comb begin
        info_o = '0;
        hold_o = '0;
        case (cls_i)
            CL_ALU: begin
                info_o.p0_ok = 1'b1;
                info_o.p1_ok = 1'b1;
            end
            CL_LOAD, CL_STORE: begin
                info_o.p0_ok = 1'b1;
            end
            CL_MUL, CL_BRANCH, CL_FPOP: begin
                info_o.p1_ok = 1'b1;
            end
            CL_PAIR, CL_OPAQUE: begin
                info_o.p0_ok = 1'b1;
                info_o.p1_ok = 1'b1;
                info_o.dual  = 1'b1;
            end
            CL_VSTQ: begin
                info_o.p0_ok      = 1'b1;
                info_o.p1_ok      = 1'b1;
                info_o.dual       = 1'b1;
                info_o.hold_pipes = 1'b1;
                hold_o            = HOLD_W'(1);
            end
            CL_IDIV: begin
                info_o.p1_ok   = 1'b1;
                info_o.use_div = 1'b1;
                hold_o         = HOLD_W'(IDIV_HOLD);
            end
            CL_FDIVS: begin
                info_o.p1_ok   = 1'b1;
                info_o.use_div = 1'b1;
                hold_o         = HOLD_W'(FDIVS_HOLD);
            end
            CL_FDIVD: begin
                info_o.p1_ok   = 1'b1;
                info_o.use_div = 1'b1;
                hold_o         = HOLD_W'(FDIVD_HOLD);
            end
            CL_FSQRTS: begin
                info_o.p1_ok   = 1'b1;
                info_o.use_div = 1'b1;
                hold_o         = HOLD_W'(FSQRTS_HOLD);
            end
            CL_FSQRTD: begin
                info_o.p1_ok   = 1'b1;
                info_o.use_div = 1'b1;
                hold_o         = HOLD_W'(FSQRTD_HOLD);
            end
            CL_VEC: begin
                info_o.p1_ok   = 1'b1;
                info_o.use_vec = 1'b1;
            end
            CL_VECQ: begin
                info_o.p1_ok   = 1'b1;
                info_o.use_vec = 1'b1;
                hold_o         = HOLD_W'(1);
            end
            default: begin
                info_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/ppa_busy_timer.sv
// Module: ppa_busy_timer
// Down-counter for one shared resource: a load sets the number of further
// busy cycles, and the resource reads busy while the count is non-zero.
// Assumes the caller never loads while busy.
module ppa_busy_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         busy_o
);

    logic [W-1:0] cnt_q;

    // Load on a claim, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign busy_o = (cnt_q != '0);

    // A busy resource is never claimed again.
    assert_no_claim_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && busy_o));

    // A claim with a non-zero hold shows busy in the next cycle.
    assert_claim_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && val_i != '0) |=> busy_o);

endmodule

// File: rtl/ppa_slot_arbiter.sv
// Module: ppa_slot_arbiter
// Combinational in-order issue decision for two slots: applies resource
// busy state, pipe eligibility and dual-pipe rules, and picks pipes.
// Assumes slot 0 is older than slot 1.
module ppa_slot_arbiter
    import ppa_pkg::*;
(
    input  logic      v0_i,
    input  cls_info_t i0_i,
    input  logic      v1_i,
    input  cls_info_t i1_i,
    input  logic      div_busy_i,
    input  logic      vec_busy_i,
    input  logic      pipes_held_i,
    output logic [1:0] grant_o,
    output logic [1:0] m0_o,
    output logic [1:0] m1_o
);

    logic       g0, g1;
    logic [1:0] place0;
    logic       s1_p0_only;

    // Slot 0 grant and pipe placement.
    always_comb begin
        g0 = v0_i && !pipes_held_i
             && !(i0_i.use_div && div_busy_i)
             && !(i0_i.use_vec && vec_busy_i);
        s1_p0_only = v1_i && i1_i.p0_ok && !i1_i.p1_ok && !i1_i.dual;
        if (i0_i.dual)
            place0 = 2'b11;
        else if (!i0_i.p1_ok)
            place0 = 2'b01;
        else if (!i0_i.p0_ok)
            place0 = 2'b10;
        else if (s1_p0_only)
            place0 = 2'b10;
        else
            place0 = 2'b01;
    end

    // Slot 1 grant: only beside a granted slot 0, on the remaining pipe.
    always_comb begin
        g1 = g0 && v1_i && !i0_i.dual && !i1_i.dual
             && !(i1_i.use_div && (div_busy_i || i0_i.use_div))
             && !(i1_i.use_vec && (vec_busy_i || i0_i.use_vec))
             && ((place0 == 2'b01) ? i1_i.p1_ok : i1_i.p0_ok);
    end

    // Grant and mask outputs, masks cleared when not granted.
    always_comb begin
        grant_o = {g1, g0};
        m0_o    = g0 ? place0 : 2'b00;
        m1_o    = g1 ? ~place0 : 2'b00;
    end

endmodule

// File: rtl/ppa_dual_issue.sv
// Module: ppa_dual_issue (top)
// Dual-issue pipe assignment: decodes both slot classes, tracks the
// divider, vector unit and dual-pipe hold, and grants in-order issue.
// Assumes decode presents slots in program order and holds ungranted ones.
module ppa_dual_issue
    import ppa_pkg::*;
#(
    parameter int IDIV_HOLD   = 21,
    parameter int FDIVS_HOLD  = 8,
    parameter int FDIVD_HOLD  = 18,
    parameter int FSQRTS_HOLD = 13,
    parameter int FSQRTD_HOLD = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s0_vld_i,
    input  logic [CLS_W-1:0] s0_cls_i,
    input  logic             s1_vld_i,
    input  logic [CLS_W-1:0] s1_cls_i,
    output logic [1:0]       grant_o,
    output logic [1:0]       s0_pipe_o,
    output logic [1:0]       s1_pipe_o,
    output logic             stall_o
);

    localparam int MAX_A  = (IDIV_HOLD > FDIVS_HOLD) ? IDIV_HOLD : FDIVS_HOLD;
    localparam int MAX_B  = (FDIVD_HOLD > FSQRTS_HOLD) ? FDIVD_HOLD : FSQRTS_HOLD;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_H  = (MAX_C > FSQRTD_HOLD) ? MAX_C : FSQRTD_HOLD;
    localparam int HOLD_W = $clog2(MAX_H + 1) < 1 ? 1 : $clog2(MAX_H + 1);

    cls_info_t         info [2];
    logic [HOLD_W-1:0] hold [2];
    logic [CLS_W-1:0]  cls  [2];
    logic [NUM_RES-1:0] res_load, res_busy;
    logic [HOLD_W-1:0] res_val [NUM_RES];

    assign cls[0] = s0_cls_i;
    assign cls[1] = s1_cls_i;

    // One decoder per slot.
    for (genvar s = 0; s < 2; s++) begin : g_dec
        ppa_class_decode #(
            .HOLD_W(HOLD_W), .IDIV_HOLD(IDIV_HOLD), .FDIVS_HOLD(FDIVS_HOLD),
            .FDIVD_HOLD(FDIVD_HOLD), .FSQRTS_HOLD(FSQRTS_HOLD),
            .FSQRTD_HOLD(FSQRTD_HOLD)
        ) u_dec (
            .cls_i (cls[s]),
            .info_o(info[s]),
            .hold_o(hold[s])
        );
    end

    ppa_slot_arbiter u_arb (
        .v0_i        (s0_vld_i),
        .i0_i        (info[0]),
        .v1_i        (s1_vld_i),
        .i1_i        (info[1]),
        .div_busy_i  (res_busy[RES_DIV]),
        .vec_busy_i  (res_busy[RES_VEC]),
        .pipes_held_i(res_busy[RES_PIPES]),
        .grant_o     (grant_o),
        .m0_o        (s0_pipe_o),
        .m1_o        (s1_pipe_o)
    );

    // Resource claims from granted slots; slot 0 wins the hold value.
    always_comb begin
        res_load[RES_DIV]   = (grant_o[0] && info[0].use_div) || (grant_o[1] && info[1].use_div);
        res_val[RES_DIV]    = (grant_o[0] && info[0].use_div) ? hold[0] : hold[1];
        res_load[RES_VEC]   = (grant_o[0] && info[0].use_vec) || (grant_o[1] && info[1].use_vec);
        res_val[RES_VEC]    = (grant_o[0] && info[0].use_vec) ? hold[0] : hold[1];
        res_load[RES_PIPES] = grant_o[0] && info[0].hold_pipes;
        res_val[RES_PIPES]  = hold[0];
    end

    // One busy timer per shared resource.
    for (genvar r = 0; r < NUM_RES; r++) begin : g_res
        ppa_busy_timer #(.W(HOLD_W)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .load_i(res_load[r]),
            .val_i (res_val[r]),
            .busy_o(res_busy[r])
        );
    end

    // Stall when any offered instruction is left behind.
    assign stall_o = (s0_vld_i && !grant_o[0]) || (s1_vld_i && !grant_o[1]);

    assert_in_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o[1] |-> grant_o[0]);

    assert_pipes_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_pipe_o & s1_pipe_o) == 2'b00);

    assert_pipe0_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o[0] && (s0_cls_i == CL_LOAD || s0_cls_i == CL_STORE)) |-> s0_pipe_o == 2'b01);

    assert_dual_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_pipe_o == 2'b11) |-> !grant_o[1]);

    assert_wide_store_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o[0] && s0_cls_i == CL_VSTQ) |=> grant_o == 2'b00);

    assert_stall_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_vld_i && !grant_o[0]) |-> stall_o);

endmodule

// File: tb/ppa_dual_issue_test.sv
module ppa_dual_issue_test;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       v0 = 1'b0, v1 = 1'b0;
    logic [3:0] c0 = '0, c1 = '0;
    logic [1:0] grant, p0m, p1m;
    logic       stall;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    int div_left = 0, vec_left = 0, hold_left = 0;
    logic [1:0] eg, em0, em1;
    logic es;

    always #(CLK_P/2) clk = ~clk;

    ppa_dual_issue uut (
        .clk(clk), .rst_n(rst_n),
        .s0_vld_i(v0), .s0_cls_i(c0), .s1_vld_i(v1), .s1_cls_i(c1),
        .grant_o(grant), .s0_pipe_o(p0m), .s1_pipe_o(p1m), .stall_o(stall)
    );

    function automatic bit f_dual(input logic [3:0] c);
        return c == 4'd6 || c == 4'd7 || c == 4'd15;
    endfunction
    function automatic bit f_p0(input logic [3:0] c);
        return c == 4'd0 || c == 4'd2 || c == 4'd3 || f_dual(c);
    endfunction
    function automatic bit f_p1(input logic [3:0] c);
        return !(c == 4'd2 || c == 4'd3);
    endfunction
    function automatic bit f_div(input logic [3:0] c);
        return c >= 4'd8 && c <= 4'd12;
    endfunction
    function automatic bit f_vec(input logic [3:0] c);
        return c == 4'd13 || c == 4'd14;
    endfunction
    function automatic int f_divhold(input logic [3:0] c);
        case (c)
            4'd8:  return 21;
            4'd9:  return 8;
            4'd10: return 18;
            4'd11: return 13;
            default: return 31;
        endcase
    endfunction

    task automatic compute_expected();
        bit g0, g1, s1p0only;
        logic [1:0] pl;
        g0 = v0 && hold_left == 0 && !(f_div(c0) && div_left > 0) && !(f_vec(c0) && vec_left > 0);
        s1p0only = v1 && f_p0(c1) && !f_p1(c1);
        if (f_dual(c0)) pl = 2'b11;
        else if (!f_p1(c0)) pl = 2'b01;
        else if (!f_p0(c0)) pl = 2'b10;
        else if (s1p0only) pl = 2'b10;
        else pl = 2'b01;
        g1 = g0 && v1 && !f_dual(c0) && !f_dual(c1)
             && !(f_div(c1) && (div_left > 0 || f_div(c0)))
             && !(f_vec(c1) && (vec_left > 0 || f_vec(c0)))
             && ((pl == 2'b01) ? f_p1(c1) : f_p0(c1));
        eg  = {g1, g0};
        em0 = g0 ? pl : 2'b00;
        em1 = g1 ? ~pl : 2'b00;
        es  = (v0 && !g0) || (v1 && !g1);
    endtask

    task automatic advance_model();
        bit d0, d1;
        d0 = eg[0] && f_div(c0);
        d1 = eg[1] && f_div(c1);
        if (d0) div_left = f_divhold(c0);
        else if (d1) div_left = f_divhold(c1);
        else if (div_left > 0) div_left--;
        if (eg[0] && f_vec(c0)) vec_left = (c0 == 4'd14) ? 1 : 0;
        else if (eg[1] && f_vec(c1)) vec_left = (c1 == 4'd14) ? 1 : 0;
        else if (vec_left > 0) vec_left--;
        if (eg[0] && c0 == 4'd7) hold_left = 1;
        else if (hold_left > 0) hold_left--;
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, compare all outputs against the model, then advance.
    task automatic step(input logic a0, input logic [3:0] k0,
                        input logic a1, input logic [3:0] k1, input string tag);
        @(negedge clk);
        v0 = a0; c0 = k0; v1 = a1; c1 = k1;
        #1;
        compute_expected();
        chk(tag, "grant", grant, eg);
        chk(tag, "pipe0", p0m, em0);
        chk(tag, "pipe1", p1m, em1);
        chk("R10", "stall", stall, es);
        advance_model();
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int blocked;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset, then divider free
        step(0, 4'd0, 0, 4'd0, "R1");
        chk("R1", "idle grant", grant, 0);
        step(1, 4'd8, 0, 4'd0, "R1");
        chk("R1", "div after reset", grant, 2'b01);
        // R8: count blocked cycles before the next integer divide
        blocked = 0;
        forever begin
            step(1, 4'd8, 1, 4'd0, "R8");
            if (grant[0]) break;
            blocked++;
        end
        chk("R8", "idiv blocked cycles", blocked, 21);
        blocked = 0;
        forever begin
            step(1, 4'd12, 0, 4'd0, "R8");
            if (grant[0]) break;
            blocked++;
        end
        chk("R8", "after idiv", blocked, 21);
        blocked = 0;
        forever begin
            step(1, 4'd9, 0, 4'd0, "R8");
            if (grant[0]) break;
            blocked++;
        end
        chk("R8", "after fsqrtd", blocked, 31);
        repeat (9) step(0, 4'd0, 0, 4'd0, "R8");

        // R2: two flexible
        step(1, 4'd0, 1, 4'd0, "R2");
        chk("R2", "flex pair masks", {p1m, p0m}, 4'b1001);
        // R3: same single pipe
        step(1, 4'd2, 1, 4'd3, "R3");
        chk("R3", "load+store grant", grant, 2'b01);
        step(1, 4'd4, 1, 4'd5, "R3");
        chk("R3", "branch+fp pipe", p0m, 2'b10);
        // R4: placement
        step(1, 4'd0, 1, 4'd2, "R4");
        chk("R4", "flex moves to pipe1", {p1m, p0m}, 4'b0110);
        step(1, 4'd1, 1, 4'd0, "R4");
        chk("R4", "mul forces slot1 pipe0", {p1m, p0m}, 4'b0110);
        // R6: dual classes
        step(1, 4'd6, 1, 4'd0, "R6");
        chk("R6", "pair alone", {grant, p0m}, 4'b0111);
        step(1, 4'd0, 1, 4'd15, "R6");
        chk("R6", "opaque in slot1 waits", grant, 2'b01);
        // R7: wide store blocks next cycle
        step(1, 4'd7, 0, 4'd0, "R7");
        step(1, 4'd0, 1, 4'd0, "R7");
        chk("R7", "blocked after wide store", grant, 2'b00);
        step(1, 4'd0, 1, 4'd0, "R7");
        chk("R7", "resumes", grant, 2'b11);
        // R9: wide vector hold
        step(1, 4'd14, 0, 4'd0, "R9");
        step(1, 4'd13, 0, 4'd0, "R9");
        chk("R9", "vec after vecq", grant, 2'b00);
        step(1, 4'd13, 0, 4'd0, "R9");
        step(1, 4'd13, 1, 4'd0, "R9");
        chk("R9", "vec after vec", grant, 2'b11);
        // R5: blocked slot 0 holds slot 1
        step(1, 4'd11, 0, 4'd0, "R5");
        step(1, 4'd10, 1, 4'd0, "R5");
        chk("R5", "in order", grant, 2'b00);
        chk("R10", "stall set", stall, 1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic a0, a1;
            logic [3:0] k0, k1;
            a0 = ($urandom % 5) != 0;
            a1 = ($urandom % 5) != 0;
            k0 = 4'($urandom % 16);
            k1 = 4'($urandom % 16);
            if (($urandom % 3) != 0 && f_div(k0)) k0 = 4'd0;
            step(a0, k0, a1, k1, "R5");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule